// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block connects a voice codec's sample stream to a time-division serial PCM bus. Once per frame it shifts one 8-bit transmit sample onto the bus during an assigned time slot. It also captures one 8-bit receive sample from its own assigned slot. All bus timing runs on the bit clock `clk`. Separate transmit and receive frame-sync inputs start each frame; each sync may be a short pulse or a square wave at the frame rate. A slot lasts eight bit-clock periods and carries its sample most-significant bit first.

Each direction has its own configuration: a slot number, a port select and an enable. A shared `delayed_mode` input picks one of two frame modes. When it is low, the frame-sync edge marks the start of the device's own slot and the slot number is ignored. When it is high, the frame-sync edge marks the start of the whole frame, and an internal position counter locates slot `n` at 8·n bit periods later. There are two transmit data ports, each with an output-enable and an active-low slot-active strobe for a backplane driver. There are also two receive data inputs, and only the selected one is sampled.

Samples enter through a valid/ready handshake. The port holds one sample, and `tx_ready` is high only when that buffer is empty and no transmit slot is in progress. The buffered sample is used up at the end of the slot that sends it. A slot that finds the buffer empty sends all ones. Received samples leave on `rx_data` with a one-cycle `rx_valid` strobe and no back-pressure: the consumer must take each sample in the cycle it is offered.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is asserted and after its release with no frame sync, ser_oe is 2'b00, slot_act_n is 2'b11, ser_out is 2'b00, tx_ready is 1 and rx_valid is 0.
- R2: With delayed_mode low, the first bit of the transmit slot appears after the first rising clock edge at which tx_fs is sampled high after being low. The following bits appear on the next 7 edges, MSB first, one per edge. tx_slot has no effect in this mode.
- R3: With delayed_mode high, slot n (0 to SLOTS-1, taken from tx_slot) begins 8·n rising edges after the edge that detects tx_fs. It then lasts 8 edges, MSB first.
- R4: Port select: tx_port = p drives only ser_out[p] and ser_oe[p]. The other port keeps ser_oe = 0 and ser_out = 0, and ser_out is 0 on any port that is not enabled.
- R5: slot_act_n[p] is 0 exactly in the cycles where ser_oe[p] is 1, and is 1 otherwise.
- R6: A frame sync held high triggers only one frame. Only a new low-to-high transition starts another frame. No slot is driven after SLOTS·8 bit periods have passed since the sync edge.
- R7: tx_ready is 1 only when the one-sample buffer is empty and no transmit slot is active. A byte is accepted when tx_valid and tx_ready are both high at a rising edge. It is used up at the edge that ends the slot, and tx_ready is 1 again from that edge on.
- R8: A transmit slot that finds the buffer empty is still driven, and carries 8'hFF.
- R9: With tx_en low no transmit slot is driven. With rx_en low, rx_valid stays 0.
- R10: Receive bits are sampled on the falling clock edges inside the receive slot (located from rx_fs, rx_slot and delayed_mode as in R2/R3), from rx_din[rx_port] only, MSB first. The other receive port is ignored.
- R11: rx_valid rises at the 8th rising edge after the receive slot starts and stays high for exactly one cycle, with rx_data holding the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; transmit changes on rising edges, receive samples on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| delayed_mode | input | 1 | 0: sync marks own slot; 1: sync marks frame start |
| tx_fs | input | 1 | Transmit frame sync (pulse or square wave) |
| tx_slot | input | SLOT_W | Transmit slot number used in delayed mode |
| tx_port | input | 1 | Transmit port select |
| tx_en | input | 1 | Transmit enable |
| tx_data | input | 8 | Transmit sample |
| tx_valid | input | 1 | Transmit sample valid |
| tx_ready | output | 1 | Buffer empty and no slot active |
| ser_out | output | 2 | Serial transmit data per port |
| ser_oe | output | 2 | Output-enable per port (1 = drive, 0 = high impedance) |
| slot_act_n | output | 2 | Active-low slot-active strobe per port |
| rx_fs | input | 1 | Receive frame sync (pulse or square wave) |
| rx_slot | input | SLOT_W | Receive slot number used in delayed mode |
| rx_port | input | 1 | Receive port select |
| rx_en | input | 1 | Receive enable |
| rx_din | input | 2 | Serial receive data per port |
| rx_data | output | 8 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe for a new rx_data |

## Verification
The checker tests these rules on every cycle: at most one transmit port is enabled, each slot-active strobe mirrors its port's output-enable, no drive burst lasts longer than eight cycles, tx_ready is low while a slot drives, a disabled transmitter never drives, and rx_valid is a single-cycle pulse. Only the bench's scenarios can show that the right bits land in the right slot. It sweeps every slot on both ports in delayed mode and compares the serial stream, the buffer handshake and the received byte with values computed from the slot number. Separate scenarios show that a square-wave sync starts one frame only, that slot numbers are ignored in non-delayed mode, that an underrun sends all ones, and that a disabled direction stays silent.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int SAMPLE_W  = 8;
  localparam int BIT_IDX_W = $clog2(SAMPLE_W);
  localparam int N_PORTS   = 2;
  localparam int PORT_W    = $clog2(N_PORTS);
  typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_port_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fs,
  input  logic                          delayed,
  input  logic [$clog2(SLOTS)-1:0]      slot,
  input  logic                          en,
  output logic                          active,
  output logic [BIT_IDX_W-1:0]          bit_idx
);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int POS_W    = SLOT_W + BIT_IDX_W;
  localparam int LAST_POS = SLOTS * SAMPLE_W - 1;

  logic              fs_q;
  logic              run;
  logic [POS_W-1:0]  pos;
  logic              fs_rise;
  logic [SLOT_W-1:0] target;

  assign fs_rise = fs & ~fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
      run  <= 1'b0;
      pos  <= '0;
    end else begin
      fs_q <= fs;
      if (fs_rise) begin
        run <= 1'b1;
        pos <= '0;
      end else if (run) begin
        if (pos == POS_W'(LAST_POS)) begin
          run <= 1'b0;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  assign target  = delayed ? slot : '0;
  assign active  = run && en && (pos[POS_W-1:BIT_IDX_W] == target);
  assign bit_idx = pos[BIT_IDX_W-1:0];
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_port_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic [BIT_IDX_W-1:0]  bit_idx,
  input  logic [PORT_W-1:0]     port,
  input  sample_t               data,
  input  logic                  valid,
  output logic                  ready,
  output logic [N_PORTS-1:0]    ser_out,
  output logic [N_PORTS-1:0]    ser_oe,
  output logic [N_PORTS-1:0]    slot_act_n
);
  localparam logic [BIT_IDX_W-1:0] MSB_IDX = BIT_IDX_W'(SAMPLE_W - 1);

  sample_t hold;
  logic    full;
  logic    slot_end;
  logic    bit_val;

  assign ready    = ~full & ~active;
  assign slot_end = active && (bit_idx == MSB_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (slot_end) begin
      full <= 1'b0;
    end else if (valid && ready) begin
      full <= 1'b1;
      hold <= data;
    end
  end

  assign bit_val = full ? hold[MSB_IDX - bit_idx] : 1'b1;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign ser_oe[p]     = active && (port == PORT_W'(p));
    assign ser_out[p]    = ser_oe[p] & bit_val;
    assign slot_act_n[p] = ~ser_oe[p];
  end
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_port_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic [BIT_IDX_W-1:0]  bit_idx,
  input  logic [PORT_W-1:0]     port,
  input  logic [N_PORTS-1:0]    din,
  output sample_t               data,
  output logic                  valid
);
  localparam logic [BIT_IDX_W-1:0] MSB_IDX = BIT_IDX_W'(SAMPLE_W - 1);

  sample_t shreg;
  logic    got_last;

  // capture half: falling edges, in the middle of each bit period
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      got_last <= 1'b0;
    end else begin
      if (active) begin
        shreg <= {shreg[SAMPLE_W-2:0], din[port]};
      end
      got_last <= active && (bit_idx == MSB_IDX);
    end
  end

  // hand-off half: rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= got_last;
      if (got_last) begin
        data <= shreg;
      end
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_port_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 delayed_mode,
  input  logic                 tx_fs,
  input  logic [SLOT_W-1:0]    tx_slot,
  input  logic                 tx_port,
  input  logic                 tx_en,
  input  logic [7:0]           tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [1:0]           ser_out,
  output logic [1:0]           ser_oe,
  output logic [1:0]           slot_act_n,
  input  logic                 rx_fs,
  input  logic [SLOT_W-1:0]    rx_slot,
  input  logic                 rx_port,
  input  logic                 rx_en,
  input  logic [1:0]           rx_din,
  output logic [7:0]           rx_data,
  output logic                 rx_valid
);
  logic                 tx_act;
  logic [BIT_IDX_W-1:0] tx_idx;
  logic                 rx_act;
  logic [BIT_IDX_W-1:0] rx_idx;

  pcm_slot_timer #(.SLOTS(SLOTS)) u_tx_timer (
    .clk(clk), .rst_n(rst_n), .fs(tx_fs), .delayed(delayed_mode),
    .slot(tx_slot), .en(tx_en), .active(tx_act), .bit_idx(tx_idx)
  );

  pcm_slot_timer #(.SLOTS(SLOTS)) u_rx_timer (
    .clk(clk), .rst_n(rst_n), .fs(rx_fs), .delayed(delayed_mode),
    .slot(rx_slot), .en(rx_en), .active(rx_act), .bit_idx(rx_idx)
  );

  pcm_tx_lane u_tx (
    .clk(clk), .rst_n(rst_n), .active(tx_act), .bit_idx(tx_idx),
    .port(tx_port), .data(tx_data), .valid(tx_valid), .ready(tx_ready),
    .ser_out(ser_out), .ser_oe(ser_oe), .slot_act_n(slot_act_n)
  );

  pcm_rx_lane u_rx (
    .clk(clk), .rst_n(rst_n), .active(rx_act), .bit_idx(rx_idx),
    .port(rx_port), .din(rx_din), .data(rx_data), .valid(rx_valid)
  );
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       tx_ready,
  input logic [1:0] ser_oe,
  input logic [1:0] slot_act_n,
  input logic       rx_valid
);
  logic [3:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (|ser_oe) begin
      if (run_len != 4'hF) run_len <= run_len + 1'b1;
    end else begin
      run_len <= '0;
    end
  end

  p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ser_oe));

  p_strobe_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_act_n == ~ser_oe);

  p_burst_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ser_oe) |-> (run_len < 4'd8));

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ser_oe) |-> !tx_ready);

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (ser_oe == 2'b00));

  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_ready(tx_ready),
  .ser_oe(ser_oe), .slot_act_n(slot_act_n), .rx_valid(rx_valid)
);

// File: tb/tb_pcm_slot_port.sv
module tb_pcm_slot_port;
  localparam int SLOTS  = 32;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int FRAME  = SLOTS * 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              delayed_mode = 1'b0;
  logic              tx_fs = 1'b0;
  logic [SLOT_W-1:0] tx_slot = '0;
  logic              tx_port = 1'b0;
  logic              tx_en = 1'b0;
  logic [7:0]        tx_data = '0;
  logic              tx_valid = 1'b0;
  logic              tx_ready;
  logic [1:0]        ser_out, ser_oe, slot_act_n;
  logic              rx_fs = 1'b0;
  logic [SLOT_W-1:0] rx_slot = '0;
  logic              rx_port = 1'b0;
  logic              rx_en = 1'b0;
  logic [1:0]        rx_din = '0;
  logic [7:0]        rx_data;
  logic              rx_valid;

  int n_checks = 0;
  int n_fail   = 0;

  pcm_slot_port #(.SLOTS(SLOTS)) dut (
    .clk(clk), .rst_n(rst_n), .delayed_mode(delayed_mode),
    .tx_fs(tx_fs), .tx_slot(tx_slot), .tx_port(tx_port), .tx_en(tx_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .ser_out(ser_out), .ser_oe(ser_oe), .slot_act_n(slot_act_n),
    .rx_fs(rx_fs), .rx_slot(rx_slot), .rx_port(rx_port), .rx_en(rx_en),
    .rx_din(rx_din), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // One frame: optional buffer write, sync edge, then cycle-by-cycle comparison.
  task automatic run_frame(input bit dly, input int slot, input int port,
                           input bit ten, input bit ren, input bit wr,
                           input logic [7:0] txb, input logic [7:0] rxb,
                           input int fs_len, input string tag);
    int es;
    logic [7:0] expb;
    int e_tx, e_act, e_rdy, nval, gotk;
    int tx_a, tx_e, act_a, act_e, rdy_a, rdy_e;
    logic [7:0] gotr;
    es = dly ? slot : 0;
    expb = wr ? txb : 8'hFF;
    e_tx = 0; e_act = 0; e_rdy = 0; nval = 0; gotk = -1; gotr = '0;
    tx_a = 0; tx_e = 0; act_a = 0; act_e = 0; rdy_a = 0; rdy_e = 0;
    @(posedge clk); #2;
    delayed_mode = dly; tx_slot = SLOT_W'(slot); rx_slot = SLOT_W'(slot);
    tx_port = port[0]; rx_port = port[0]; tx_en = ten; rx_en = ren;
    if (wr) begin
      tx_data = txb; tx_valid = 1'b1;
      @(posedge clk); #2;
      tx_valid = 1'b0;
      #3;
      check(tx_ready == 1'b0, {tag, " R7 buffer full after accept"}, tx_ready, 0);
    end
    tx_fs = 1'b1; rx_fs = 1'b1;
    for (int k = 0; k < FRAME + 16; k++) begin
      bit in_slot;
      bit oe_on;
      int bi;
      logic [1:0] exp_oe, exp_out;
      logic exp_rdy;
      logic b;
      @(posedge clk); #5;
      in_slot = (k >= es * 8) && (k < es * 8 + 8);
      oe_on = in_slot && ten;
      bi = in_slot ? (7 - (k - es * 8)) : 0;
      exp_oe = oe_on ? (2'b01 << port) : 2'b00;
      exp_out = (oe_on && expb[bi]) ? (2'b01 << port) : 2'b00;
      if ({ser_oe, ser_out} != {exp_oe, exp_out}) begin
        if (e_tx == 0) begin tx_a = {ser_oe, ser_out}; tx_e = {exp_oe, exp_out}; end
        e_tx++;
      end
      if (slot_act_n != ~exp_oe) begin
        if (e_act == 0) begin act_a = slot_act_n; act_e = ~exp_oe; end
        e_act++;
      end
      exp_rdy = (ten && in_slot) ? 1'b0 : ((ten && k >= es * 8 + 8) ? 1'b1 : !wr);
      if (tx_ready != exp_rdy) begin
        if (e_rdy == 0) begin rdy_a = tx_ready; rdy_e = exp_rdy; end
        e_rdy++;
      end
      if (rx_valid) begin nval++; gotk = k; gotr = rx_data; end
      if (in_slot) begin
        b = rxb[bi];
        rx_din[port] = b;
        rx_din[1 - port] = ~b;
      end else begin
        rx_din = 2'(k);
      end
      if (k == fs_len - 1) begin tx_fs = 1'b0; rx_fs = 1'b0; end
    end
    tx_fs = 1'b0; rx_fs = 1'b0; rx_din = '0;
    check(e_tx == 0, {tag, " R4 tx stream (oe,out)"}, tx_a, tx_e);
    check(e_act == 0, {tag, " R5 slot_act_n"}, act_a, act_e);
    check(e_rdy == 0, {tag, " R7 tx_ready"}, rdy_a, rdy_e);
    if (ren) begin
      check(nval == 1, {tag, " R11 rx_valid pulse count"}, nval, 1);
      check(gotk == es * 8 + 8, {tag, " R11 rx_valid cycle"}, gotk, es * 8 + 8);
      check(gotr == rxb, {tag, " R10 rx_data"}, gotr, rxb);
    end else begin
      check(nval == 0, {tag, " R9 rx_valid with rx off"}, nval, 0);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check({ser_oe, slot_act_n, ser_out} == 6'b001100, "R1 outputs in reset",
          {ser_oe, slot_act_n, ser_out}, 6'b001100);
    check(tx_ready == 1'b1 && rx_valid == 1'b0, "R1 ready/valid in reset",
          {tx_ready, rx_valid}, 2'b10);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    check({ser_oe, slot_act_n, ser_out} == 6'b001100, "R1 outputs idle after reset",
          {ser_oe, slot_act_n, ser_out}, 6'b001100);

    // R3: every slot on both ports in delayed mode
    for (int s = 0; s < SLOTS; s++) begin
      for (int p = 0; p < 2; p++) begin
        logic [7:0] tb_byte;
        logic [7:0] rb_byte;
        tb_byte = 8'(s * 29 + p * 101 + 7);
        rb_byte = ~tb_byte ^ 8'(s << 2);
        run_frame(1'b1, s, p, 1'b1, 1'b1, 1'b1, tb_byte, rb_byte, 1, "R3 delayed sweep");
      end
    end

    // R2: non-delayed mode ignores the slot number
    run_frame(1'b0, 5, 0, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C, 1, "R2 non-delayed slot5");
    run_frame(1'b0, 31, 1, 1'b1, 1'b1, 1'b1, 8'h81, 8'hE7, 4, "R2 non-delayed slot31");

    // R6: square-wave sync held high past the frame triggers once
    run_frame(1'b1, 3, 1, 1'b1, 1'b1, 1'b1, 8'h5A, 8'h96, FRAME + 10, "R6 square sync");
    run_frame(1'b1, 31, 0, 1'b1, 1'b1, 1'b1, 8'hC3, 8'h18, FRAME / 2, "R6 half-frame sync");

    // R8: underrun sends all ones
    run_frame(1'b1, 9, 0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h42, 1, "R8 underrun");
    run_frame(1'b0, 0, 1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFE, 1, "R8 underrun non-delayed");

    // R9: both directions disabled
    run_frame(1'b1, 7, 1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h77, 1, "R9 disabled");

    // R10: receive only, transmit disabled
    run_frame(1'b1, 12, 1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h01, 1, "R10 rx only");

    summary();
    $finish;
  end
endmodule